// File: doc/BRIEF.md
# MDIO Management Master

This block runs Clause 22 management frames to external PHY devices. Software works it through a small 32-bit register window. It first loads the value to be written, if there is one. It then writes a single command word that holds the PHY address, the PHY register number, the start code, the opcode and a go bit. The frame runs on its own after that write. Software polls the go bit, which stays set while the frame is on the wire. For a read, software then takes the 16-bit result and checks a status bit that reports whether any PHY answered.

The management clock is made from the system clock by a divider. Its half period is set by the `MDC_HALF` parameter. The default of 50 gives 2.5 MHz from a 250 MHz system clock. The block drives the serial line through a data/enable pair. For a read it releases the line during turnaround and the data phase, and samples the line on each rising management-clock edge.

Top module: `mdio_master`

## Requirements
- R1: Register window, by byte offset on `reg_addr`. 0x00 is the command word. 0x04 is a 32-bit scratch register that software can read and write and that has no effect on frames. 0x08 holds the write value: only the low 16 bits are stored, and the upper 16 read as zero. 0x0C holds the read result in bits [15:0], with the upper bits reading zero. 0x10 is the status word. Any other offset reads zero.
- R2: Command word layout: [4:0] PHY register, [9:5] PHY address, [11:10] opcode (10 = read, any other value is sent as a write), [13:12] start code, [14] go/busy. It reads back as those fields with bit 14 showing busy and bits [31:15] zero. A command written with bit 14 clear only stores the fields and sends nothing.
- R3: A command written with bit 14 set sends one 64-bit frame on `mdio_out`, MSB first. The frame is 32 ones, then cmd[13:12], cmd[11:10], the PHY address, the register number, and the turnaround. For a write the turnaround is 10, followed by the low 16 bits of the write value, and `mdio_oe` stays high for all 64 bits.
- R4: For a read, `mdio_oe` is low for the last 18 bit times, which are the turnaround and the data. The 16 data bits are sampled MSB first on rising `mdc`. Read data offset 0x0C then holds them in bits [15:0].
- R5: If `mdio_in` is high when the second turnaround bit is sampled, the read is marked as unanswered. Status bit 1 is set and the read result becomes 0xFFFF. A read that was answered clears status bit 1. Write frames leave the status bit unchanged.
- R6: The busy bit reads 1 from the command write until the last falling `mdc` of the frame. It reads 0 from one system clock after that edge.
- R7: A command write while busy is 1 has no effect. The frame in progress, the stored command fields, and the total number of frames all stay unchanged.
- R8: `mdc` is low whenever the block is not busy. While a frame runs, `mdc` holds each level for exactly `MDC_HALF` system clocks. `mdio_out` changes only while `mdc` is low, never on a rising edge.
- R9: After reset, every register reads zero, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Serial line value seen at the pad |
| mdio_out | output | 1 | Serial line value to drive |
| mdio_oe | output | 1 | Drive enable for the serial line |

## Verification
The hardest case to reach is a command word that arrives in the middle of a frame. It has to be written while the serial clock is already toggling, and it must leave no trace. The bench starts a write frame and waits until a monitor has counted ten rising `mdc` edges. It then writes a read command to a different PHY. Afterwards it compares the captured frame, the command readback and the total rising-edge count against the first command alone.

A second hard case is the exact clock in which busy drops. The bench waits for the final falling `mdc` edge and reads the command word twice, one system clock apart. The unanswered read is produced by a bench PHY model that stays silent, so the line floats high through turnaround.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int MII_W  = 16;
    localparam int FLD_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_XADR = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_WDAT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RDAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h10;

    localparam int GO_BIT     = 14;
    localparam int NORESP_BIT = 1;

    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(46);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(47);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(48);

    localparam logic [1:0] OP_RD = 2'b10;

    typedef struct packed {
        logic [1:0]       st;
        logic [1:0]       op;
        logic [FLD_W-1:0] phy;
        logic [FLD_W-1:0] regn;
    } mgmt_cmd_t;

    localparam int CMD_W = $bits(mgmt_cmd_t);

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_RUN,
        SH_DONE
    } sh_state_t;

    function automatic logic is_rd(mgmt_cmd_t c);
        return c.op == OP_RD;
    endfunction

    function automatic mgmt_cmd_t decode_cmd(logic [BUS_W-1:0] w);
        mgmt_cmd_t c;
        c.regn = w[4:0];
        c.phy  = w[9:5];
        c.op   = w[11:10];
        c.st   = w[13:12];
        return c;
    endfunction

    function automatic logic [FRAME_LEN-1:0] frame_bits(mgmt_cmd_t c, logic [MII_W-1:0] d);
        logic [1:0]       ta;
        logic [MII_W-1:0] body;
        ta   = is_rd(c) ? 2'b11 : 2'b10;
        body = is_rd(c) ? {MII_W{1'b1}} : d;
        return {{32{1'b1}}, c.st, c.op, c.phy, c.regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [BUS_W-1:0]      reg_wdata,
    output logic [BUS_W-1:0]      reg_rdata,
    input  logic                  done,
    input  logic                  done_read,
    input  logic                  noresp,
    input  logic [MII_W-1:0]      rd_value,
    output logic                  busy,
    output logic                  go,
    output mgmt_cmd_t             cmd,
    output logic [MII_W-1:0]      wdat
);

    logic [BUS_W-1:0] xadr_q;
    logic [MII_W-1:0] rdat_q;
    logic             noresp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            go       <= 1'b0;
            cmd      <= '0;
            wdat     <= '0;
            xadr_q   <= '0;
            rdat_q   <= '0;
            noresp_q <= 1'b0;
        end else begin
            go <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CMD: begin
                        if (!busy) begin
                            cmd <= decode_cmd(reg_wdata);
                            if (reg_wdata[GO_BIT]) begin
                                busy <= 1'b1;
                                go   <= 1'b1;
                            end
                        end
                    end
                    OFS_XADR: xadr_q <= reg_wdata;
                    OFS_WDAT: wdat   <= reg_wdata[MII_W-1:0];
                    default: ;
                endcase
            end
            if (done) begin
                busy <= 1'b0;
            end
            if (done_read) begin
                rdat_q   <= noresp ? {MII_W{1'b1}} : rd_value;
                noresp_q <= noresp;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:  reg_rdata = {{(BUS_W-CMD_W-1){1'b0}}, busy, cmd};
            OFS_XADR: reg_rdata = xadr_q;
            OFS_WDAT: reg_rdata = {{(BUS_W-MII_W){1'b0}}, wdat};
            OFS_RDAT: reg_rdata = {{(BUS_W-MII_W){1'b0}}, rdat_q};
            OFS_STAT: reg_rdata[NORESP_BIT] = noresp_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int MDC_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);

    localparam int CW = (MDC_HALF > 2) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CNT_TOP);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  mgmt_cmd_t        cmd,
    input  logic [MII_W-1:0] wdat,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             run,
    output logic             done,
    output logic             done_read,
    output logic             noresp,
    output logic [MII_W-1:0] rd_value
);

    sh_state_t             state;
    logic [FRAME_LEN-1:0]  sh;
    logic [IDX_W-1:0]      idx;
    logic                  rd_q;
    logic                  miss_q;
    logic [MII_W-1:0]      cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            sh     <= '1;
            idx    <= '0;
            rd_q   <= 1'b0;
            miss_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (go) begin
                        sh     <= frame_bits(cmd, wdat);
                        idx    <= '0;
                        rd_q   <= is_rd(cmd);
                        miss_q <= 1'b0;
                        state  <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (rise_evt && rd_q) begin
                        if (idx == TA2_IDX) begin
                            miss_q <= mdio_in;
                        end
                        if (idx >= DAT_IDX) begin
                            cap_q <= {cap_q[MII_W-2:0], mdio_in};
                        end
                    end
                    if (fall_evt) begin
                        if (idx == LAST_IDX) begin
                            state <= SH_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                            sh  <= {sh[FRAME_LEN-2:0], 1'b1};
                        end
                    end
                end
                SH_DONE: state <= SH_IDLE;
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign run       = (state == SH_RUN);
    assign done      = (state == SH_DONE);
    assign done_read = done && rd_q;
    assign noresp    = miss_q;
    assign rd_value  = cap_q;
    assign mdio_out  = run ? sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe   = run && !(rd_q && (idx >= REL_IDX));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic             busy_w;
    logic             go_w;
    mgmt_cmd_t        cmd_w;
    logic [MII_W-1:0] wdat_w;
    logic             run_w;
    logic             done_w;
    logic             done_rd_w;
    logic             noresp_w;
    logic [MII_W-1:0] rdv_w;
    logic             rise_w;
    logic             fall_w;

    mdio_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done_w),
        .done_read (done_rd_w),
        .noresp    (noresp_w),
        .rd_value  (rdv_w),
        .busy      (busy_w),
        .go        (go_w),
        .cmd       (cmd_w),
        .wdat      (wdat_w)
    );

    mdio_clkdiv #(.MDC_HALF(MDC_HALF)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run_w),
        .mdc      (mdc),
        .rise_evt (rise_w),
        .fall_evt (fall_w)
    );

    mdio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .go        (go_w),
        .cmd       (cmd_w),
        .wdat      (wdat_w),
        .rise_evt  (rise_w),
        .fall_evt  (fall_w),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .run       (run_w),
        .done      (done_w),
        .done_read (done_rd_w),
        .noresp    (noresp_w),
        .rd_value  (rdv_w)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 50
) (
    input logic            clk,
    input logic            rst,
    input logic            mdc,
    input logic            mdio_out,
    input logic            mdio_oe,
    input logic            busy,
    input logic            frame_run,
    input logic [CMD_W-1:0] cmd_q
);

    localparam int HW = $clog2(MDC_HALF + 2) + 1;

    logic          mdc_d;
    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d    <= 1'b0;
            hold_cnt <= '0;
        end else begin
            mdc_d <= mdc;
            if (!frame_run) begin
                hold_cnt <= '0;
            end else if (mdc != mdc_d) begin
                hold_cnt <= HW'(1);
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // R8
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R8
    mdc_half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (mdc != mdc_d)) |-> (hold_cnt == HW'(MDC_HALF)));

    // R8
    mdio_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mdio_out != $past(mdio_out)) |-> !mdc);

    // R6
    busy_until_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mdc) |=> busy);

    // R7
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

    // R4
    oe_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

endmodule

bind mdio_master mdio_master_chk #(.MDC_HALF(MDC_HALF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .busy      (busy_w),
    .frame_run (run_w),
    .cmd_q     (cmd_w)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_in;
    logic        mdio_out;
    logic        mdio_oe;

    int          n_chk = 0;
    int          n_fail = 0;
    int          rises = 0;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    logic        phy_here = 1'b0;
    logic [15:0] phy_val = '0;
    time         last_rise = 0;
    logic        bad_period = 1'b0;
    logic        finished = 1'b0;

    always #2 clk = !clk;

    mdio_master #(.MDC_HALF(HALF)) u_mdio_master (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    // PHY model: pulls turnaround low and returns data when present
    always_comb begin
        mdio_in = 1'b1;
        if (phy_here && rises == 47) mdio_in = 1'b0;
        else if (phy_here && rises >= 48 && rises <= 63) mdio_in = phy_val[63 - rises];
    end

    // Line monitor
    always @(posedge mdc) begin
        cap   = {cap[62:0], mdio_oe ? mdio_out : mdio_in};
        oecap = {oecap[62:0], mdio_oe};
        if (rises > 0 && ($time - last_rise) != 2 * HALF * 4) bad_period = 1'b1;
        last_rise = $time;
        rises = rises + 1;
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic launch(input logic [31:0] w);
        rises = 0;
        cap = '0;
        oecap = '0;
        wr(5'h00, w);
    endtask

    task automatic wait_idle;
        logic [31:0] v;
        v = 32'h4000;
        while (v[14]) rd(5'h00, v);
    endtask

    function automatic logic [31:0] cmdw(logic rdop, logic [4:0] phy, logic [4:0] rg);
        return 32'h4000 | 32'h1000 | (rdop ? 32'h0800 : 32'h0400) | ({27'd0, phy} << 5) | {27'd0, rg};
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); check(v == 0, "R9 cmd reset", {32'd0, v}, 64'd0);
        rd(5'h04, v); check(v == 0, "R9 scratch reset", {32'd0, v}, 64'd0);
        rd(5'h0C, v); check(v == 0, "R9 rdata reset", {32'd0, v}, 64'd0);
        rd(5'h10, v); check(v == 0, "R9 status reset", {32'd0, v}, 64'd0);
        check(!mdc && !mdio_oe, "R9 pins reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(5'h04, 32'hDEADBEEF);
        rd(5'h04, v); check(v == 32'hDEADBEEF, "R1 scratch", {32'd0, v}, 64'hDEADBEEF);
        wr(5'h08, 32'hFFFF1234);
        rd(5'h08, v); check(v == 32'h00001234, "R1 wdata low16", {32'd0, v}, 64'h1234);
        rd(5'h14, v); check(v == 0, "R1 unmapped", {32'd0, v}, 64'd0);
    endtask

    task automatic t_nostart;
        logic [31:0] v;
        launch(cmdw(1'b0, 5'd7, 5'd3) & ~32'h4000);
        repeat (100) @(posedge clk);
        check(rises == 0, "R2 no frame without go", 64'(rises), 64'd0);
        rd(5'h00, v);
        check(v == 32'h000014E3, "R2 fields stored", {32'd0, v}, 64'h14E3);
    endtask

    task automatic t_write;
        logic [63:0] exp;
        launch(cmdw(1'b0, 5'd5, 5'h11));
        wait_idle();
        exp = {32'hFFFFFFFF, 2'b01, 2'b01, 5'd5, 5'h11, 2'b10, 16'h1234};
        check(cap == exp, "R3 write frame", cap, exp);
        check(oecap == '1, "R3 driven whole frame", oecap, '1);
        check(!bad_period, "R8 mdc period", {63'd0, bad_period}, 64'd0);
    endtask

    task automatic t_busy_edge;
        logic [31:0] v;
        wr(5'h08, 32'h0000A5C3);
        launch(cmdw(1'b0, 5'd2, 5'd9));
        rd(5'h00, v); check(v[14], "R6 busy set", {63'd0, v[14]}, 64'd1);
        wait (rises == 64);
        @(negedge mdc);
        rd(5'h00, v); check(v[14] == 1'b1, "R6 busy at last fall", {63'd0, v[14]}, 64'd1);
        rd(5'h00, v); check(v[14] == 1'b0, "R6 busy clear next clk", {63'd0, v[14]}, 64'd0);
        check(cap[15:0] == 16'hA5C3, "R3 data msb first", {48'd0, cap[15:0]}, 64'hA5C3);
    endtask

    task automatic t_read_ok(input logic [15:0] d);
        logic [31:0] v;
        logic [45:0] hdr;
        phy_here = 1'b1;
        phy_val  = d;
        launch(cmdw(1'b1, 5'd1, 5'd2));
        wait_idle();
        hdr = {32'hFFFFFFFF, 2'b01, 2'b10, 5'd1, 5'd2};
        check(cap[63:18] == hdr, "R4 read header", {18'd0, cap[63:18]}, {18'd0, hdr});
        check(oecap[17:0] == 0 && oecap[63:18] == '1, "R4 release", oecap, {46'h3FFFFFFFFFFF, 18'd0});
        rd(5'h0C, v); check(v == {16'd0, d}, "R4 read data", {32'd0, v}, {48'd0, d});
        rd(5'h10, v); check(v == 0, "R5 answered read status", {32'd0, v}, 64'd0);
    endtask

    task automatic t_read_miss;
        logic [31:0] v;
        phy_here = 1'b0;
        launch(cmdw(1'b1, 5'd30, 5'd1));
        wait_idle();
        rd(5'h10, v); check(v == 32'h2, "R5 no response status", {32'd0, v}, 64'h2);
        rd(5'h0C, v); check(v == 32'hFFFF, "R5 ones data", {32'd0, v}, 64'hFFFF);
        wr(5'h08, 32'h0);
        launch(cmdw(1'b0, 5'd4, 5'd4));
        wait_idle();
        rd(5'h10, v); check(v == 32'h2, "R5 write keeps status", {32'd0, v}, 64'h2);
    endtask

    task automatic t_ignore;
        logic [31:0] v;
        logic [63:0] exp;
        wr(5'h08, 32'h00000F0F);
        launch(cmdw(1'b0, 5'd3, 5'd2));
        wait (rises == 10);
        wr(5'h00, cmdw(1'b1, 5'd9, 5'd9));
        wait_idle();
        exp = {32'hFFFFFFFF, 2'b01, 2'b01, 5'd3, 5'd2, 2'b10, 16'h0F0F};
        check(cap == exp, "R7 frame unchanged", cap, exp);
        rd(5'h00, v); check(v == (cmdw(1'b0, 5'd3, 5'd2) & ~32'h4000), "R7 fields unchanged", {32'd0, v}, {32'd0, cmdw(1'b0, 5'd3, 5'd2) & ~32'h4000});
        repeat (200) @(posedge clk);
        check(rises == 64, "R7 single frame", 64'(rises), 64'd64);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_nostart();
        t_write();
        t_busy_edge();
        t_read_ok(16'hBEEF);
        t_read_ok(16'h8001);
        t_read_miss();
        t_read_ok(16'h5A3C);
        t_ignore();
        check(!bad_period, "R8 mdc period all frames", {63'd0, bad_period}, 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule